// File: doc/BRIEF.md
# Nibble-Written Bank Mapper Registers

This block sits on the cartridge side of an 8-bit console. It watches CPU writes to the upper half of the address space and keeps the banking state: two switchable 8 KB program banks, a swap flag that moves the first of them between two CPU windows, a two-bit nametable mirroring mode, and eight 1 KB character banks. Each character bank register is eight bits wide. Software loads it four bits at a time through two separately addressed writes.

From that state the block forms three combinational outputs. The first is the program bank number for whichever 8 KB CPU window is being addressed. The second is the full character-ROM address for a PPU pattern fetch. The third is the page-select line for the nametable RAM. One decoder accepts two different pairs of low address lines as sub-register selectors. This lets the same logic serve boards that route different CPU address pins to the register-select inputs.

Top module: `nbm_mapper`

## Requirements
- R1: After reset, character bank k holds k for k = 0..7, the swap flag is clear, the mirroring mode is vertical, and the four CPU windows 0x8000/0xA000/0xC000/0xE000 map banks 0, 1, N-2 and N-1 (N = PRG_BANKS).
- R2: In the character pages (CPU page 0xB for banks 0-1, 0xC for 2-3, 0xD for 4-5, 0xE for 6-7), offset 0x000 loads data[3:0] into bits 3:0 of the even bank, and offset 0x002 or 0x040 loads data[3:0] into bits 7:4 of the even bank. The other nibble keeps its value.
- R3: In the same pages, offset 0x001, 0x004 or 0x080 loads bits 3:0 of the odd bank, and offset 0x003, 0x006 or 0x0C0 loads bits 7:4 of the odd bank. The other nibble keeps its value.
- R4: Decoding looks only at the CPU address ANDed with 0xF0CF, so address bits 11:8 and 5:4 do not affect which register a write reaches.
- R5: A write to any other masked address leaves all state unchanged. This includes unlisted offsets in a decoded page and pages below 0x8 or equal to 0xF. A cycle with the write strobe low also leaves all state unchanged.
- R6: chr_addr equals {bank[ppu_addr[12:10]], ppu_addr[9:0]}.
- R7: A write to 0x9000 sets the mirroring mode from data[1:0]. The modes are 0 vertical (nt_page = ppu_addr[10]), 1 horizontal (nt_page = ppu_addr[11]), 2 single lower (nt_page = 0) and 3 single upper (nt_page = 1).
- R8: A write to 0x9002 or 0x9080 sets the swap flag to data[1]. The other data bits are ignored.
- R9: With the swap flag clear, window 0x8000 maps the bank written at 0x8000, window 0xA000 maps the bank written at 0xA000, window 0xC000 maps bank N-2, and window 0xE000 maps bank N-1.
- R10: With the swap flag set, window 0x8000 maps bank N-2 and window 0xC000 maps the bank written at 0x8000. Windows 0xA000 and 0xE000 are unchanged.
- R11: Program bank writes store the data byte reduced modulo PRG_BANKS.
- R12: Character nibble writes use data[3:0] only. Data bits 7:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are captured on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for both write decode and window select |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | PPU address bits 12:0 |
| prg_bank | output | $clog2(PRG_BANKS) | Program bank for the window selected by cpu_addr[14:13] |
| chr_addr | output | 18 | Character-ROM address: selected bank and ppu_addr[9:0] |
| nt_page | output | 1 | Nametable RAM page select |

## Verification
Every one of the nine accepted sub-register offsets is written in all four character pages. Alternate writes carry noise in the ignored address bits and junk in data bits 7:4. After each write all eight banks are read back through chr_addr. This shows which nibble of which register each alias reaches, and that the neighbouring nibble and the other banks are untouched. Writes to offsets that differ from a valid one by a single bit (0x005, 0x008, 0x041), to out-of-range pages, and with the strobe low confirm that near misses are ignored. Each mirroring mode is crossed with all four A11/A10 combinations, which separates the two address-following modes from the two constant ones. The program windows are read in both swap states. The swap register is reached through both aliases, with junk in the unused data bits, so the flag is shown to follow bit 1 alone.

// File: rtl/nbm_pkg.sv
// Shared constants and types for the nibble-written bank mapper.
// Assumes a 16-bit CPU address space and 1 KB character banks.
package nbm_pkg;
    localparam int CHR_REGS   = 8;
    localparam int NIB        = 4;
    localparam int CHR_BW     = 2 * NIB;
    localparam int PPU_OFS_W  = 10;
    localparam int CHR_SEL_W  = $clog2(CHR_REGS);
    localparam logic [15:0] DEC_MASK = 16'hF0CF;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mir_mode_t;

    typedef enum logic [2:0] {
        SUB_NONE,
        SUB_EVEN_LO,
        SUB_EVEN_HI,
        SUB_ODD_LO,
        SUB_ODD_HI
    } sub_sel_t;

    // Maps the low 12 bits of a masked address to a character sub-register.
    function automatic sub_sel_t classify_ofs(input logic [11:0] ofs);
        case (ofs)
            12'h000:                   return SUB_EVEN_LO;
            12'h002, 12'h040:          return SUB_EVEN_HI;
            12'h001, 12'h004, 12'h080: return SUB_ODD_LO;
            12'h003, 12'h006, 12'h0C0: return SUB_ODD_HI;
            default:                   return SUB_NONE;
        endcase
    endfunction
endpackage

// File: rtl/nbm_wr_decode.sv
// Write decoder: turns one strobed CPU write into at most one register
// enable. Assumes the address is stable while cpu_we is high; only bits
// kept by DEC_MASK take part in the match.
module nbm_wr_decode
    import nbm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_we,
    input  logic [15:0]         cpu_addr,
    output logic [CHR_REGS-1:0] chr_lo_we,
    output logic [CHR_REGS-1:0] chr_hi_we,
    output logic                prg_a_we,
    output logic                prg_b_we,
    output logic                swap_we,
    output logic                mir_we
);
    logic [15:0] masked;
    sub_sel_t    sel;
    int          pair;

    assign masked = cpu_addr & DEC_MASK;
    assign sel    = classify_ofs(masked[11:0]);

    // Select the single target register for the current write.
    always_comb begin
        chr_lo_we = '0;
        chr_hi_we = '0;
        prg_a_we  = 1'b0;
        prg_b_we  = 1'b0;
        swap_we   = 1'b0;
        mir_we    = 1'b0;
        pair      = int'(masked[15:12]) - 11;
        if (cpu_we) begin
            case (masked[15:12])
                4'h8: prg_a_we = (masked[11:0] == 12'h000);
                4'h9: begin
                    mir_we  = (masked[11:0] == 12'h000);
                    swap_we = (masked[11:0] == 12'h002) || (masked[11:0] == 12'h080);
                end
                4'hA: prg_b_we = (masked[11:0] == 12'h000);
                4'hB, 4'hC, 4'hD, 4'hE: begin
                    chr_lo_we[2*pair]     = (sel == SUB_EVEN_LO);
                    chr_hi_we[2*pair]     = (sel == SUB_EVEN_HI);
                    chr_lo_we[2*pair + 1] = (sel == SUB_ODD_LO);
                    chr_hi_we[2*pair + 1] = (sel == SUB_ODD_HI);
                end
                default: ;
            endcase
        end
    end

    // R3, R5: a write reaches at most one register.
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chr_lo_we, chr_hi_we, prg_a_we, prg_b_we, swap_we, mir_we}));

    // R5: no enable without the strobe.
    a_r5_no_strobe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |-> ({chr_lo_we, chr_hi_we, prg_a_we, prg_b_we, swap_we, mir_we} == '0));
endmodule

// File: rtl/nbm_chr_banks.sv
// Eight character bank registers, each loaded one nibble at a time, plus
// the read mux that picks the bank for the current PPU 1 KB slot.
// Assumes at most one of lo_we/hi_we is set per register in a cycle.
module nbm_chr_banks
    import nbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CHR_REGS-1:0]  lo_we,
    input  logic [CHR_REGS-1:0]  hi_we,
    input  logic [NIB-1:0]       nib,
    input  logic [CHR_SEL_W-1:0] slot,
    output logic [CHR_BW-1:0]    bank
);
    logic [CHR_REGS-1:0][CHR_BW-1:0] bank_q;

    for (genvar k = 0; k < CHR_REGS; k++) begin : g_reg
        // Hold one bank register; reset to its own index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[k] <= CHR_BW'(k);
            else if (lo_we[k])
                bank_q[k][NIB-1:0] <= nib;
            else if (hi_we[k])
                bank_q[k][CHR_BW-1:NIB] <= nib;
        end

        // R1: reset value equals the register index.
        a_r1_chr_reset: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (bank_q[k] == CHR_BW'(k)));

        // R2: a low-nibble write keeps the high nibble.
        a_r2_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
            lo_we[k] |=> $stable(bank_q[k][CHR_BW-1:NIB]));

        // R3: a high-nibble write keeps the low nibble.
        a_r3_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
            hi_we[k] |=> $stable(bank_q[k][NIB-1:0]));

        // R5: an untargeted register holds.
        a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(lo_we[k] || hi_we[k]) |=> $stable(bank_q[k]));
    end

    assign bank = bank_q[slot];
endmodule

// File: rtl/nbm_prg_map.sv
// Program bank registers, swap flag and window mapper. Assumes
// PRG_BANKS >= 4; stored banks are reduced modulo PRG_BANKS.
module nbm_prg_map #(
    parameter int PRG_BANKS = 16,
    localparam int PRG_BW   = $clog2(PRG_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prg_a_we,
    input  logic              prg_b_we,
    input  logic              swap_we,
    input  logic [7:0]        wdata,
    input  logic [1:0]        cpu_win,
    output logic [PRG_BW-1:0] prg_bank
);
    localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);
    localparam logic [PRG_BW-1:0] NEXT_LAST = PRG_BW'(PRG_BANKS - 2);

    logic [PRG_BW-1:0] bank_a_q, bank_b_q;
    logic              swap_q;
    logic [PRG_BW-1:0] win_bank [4];
    logic [PRG_BW-1:0] wbank;

    assign wbank = PRG_BW'(wdata % PRG_BANKS);

    // Hold the two switchable banks and the swap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_a_q <= '0;
            bank_b_q <= PRG_BW'(1);
            swap_q   <= 1'b0;
        end else begin
            if (prg_a_we) bank_a_q <= wbank;
            if (prg_b_we) bank_b_q <= wbank;
            if (swap_we)  swap_q   <= wdata[1];
        end
    end

    // Work out the bank behind each of the four 8 KB CPU windows.
    always_comb begin
        win_bank[0] = swap_q ? NEXT_LAST : bank_a_q;
        win_bank[1] = bank_b_q;
        win_bank[2] = swap_q ? bank_a_q : NEXT_LAST;
        win_bank[3] = LAST_BANK;
    end

    assign prg_bank = win_bank[cpu_win];

    // R8: the swap flag takes data bit 1 of its write.
    a_r8_swap_load: assert property (@(posedge clk) disable iff (!rst_n)
        swap_we |=> (swap_q == $past(wdata[1])));

    // R10: second-to-last bank always sits in the 0x8000 or 0xC000 window.
    a_r10_fixed_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (win_bank[0] == NEXT_LAST) || (win_bank[2] == NEXT_LAST));

    // R11: stored banks never exceed the bank count.
    a_r11_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bank_a_q) < PRG_BANKS) && (int'(bank_b_q) < PRG_BANKS));
endmodule

// File: rtl/nbm_mapper.sv
// Top of the nibble-written bank mapper: write decode, character bank
// file, program mapper and the mirroring register with the nametable
// page-select. Writes are captured on one clock edge while cpu_we is high.
module nbm_mapper
    import nbm_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    localparam int PRG_BW   = $clog2(PRG_BANKS),
    localparam int CHR_AW   = CHR_BW + PPU_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_BW-1:0] prg_bank,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_page
);
    logic [CHR_REGS-1:0] chr_lo_we, chr_hi_we;
    logic                prg_a_we, prg_b_we, swap_we, mir_we;
    logic [CHR_BW-1:0]   chr_bank;
    mir_mode_t           mir_q;

    nbm_wr_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .chr_lo_we (chr_lo_we),
        .chr_hi_we (chr_hi_we),
        .prg_a_we  (prg_a_we),
        .prg_b_we  (prg_b_we),
        .swap_we   (swap_we),
        .mir_we    (mir_we)
    );

    nbm_chr_banks u_chr (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (chr_lo_we),
        .hi_we (chr_hi_we),
        .nib   (cpu_data[NIB-1:0]),
        .slot  (ppu_addr[PPU_OFS_W +: CHR_SEL_W]),
        .bank  (chr_bank)
    );

    nbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .prg_a_we (prg_a_we),
        .prg_b_we (prg_b_we),
        .swap_we  (swap_we),
        .wdata    (cpu_data),
        .cpu_win  (cpu_addr[14:13]),
        .prg_bank (prg_bank)
    );

    assign chr_addr = {chr_bank, ppu_addr[PPU_OFS_W-1:0]};

    // Hold the mirroring mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mir_q <= MIR_VERT;
        else if (mir_we)
            mir_q <= mir_mode_t'(cpu_data[1:0]);
    end

    // Derive the nametable page from the mode and PPU A11/A10.
    always_comb begin
        case (mir_q)
            MIR_VERT:   nt_page = ppu_addr[10];
            MIR_HORZ:   nt_page = ppu_addr[11];
            MIR_ONE_LO: nt_page = 1'b0;
            default:    nt_page = 1'b1;
        endcase
    end

    // R7: the mode follows data[1:0] of its write.
    a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mir_we |=> (mir_q == mir_mode_t'($past(cpu_data[1:0]))));

    // R7: single-screen modes give a fixed page whatever the PPU address.
    a_r7_single_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_q == MIR_ONE_LO || mir_q == MIR_ONE_HI) |-> (nt_page == mir_q[0]));
endmodule

// File: tb/nbm_mapper_test.sv
// Sweep bench for nbm_mapper with 16 program banks.
module nbm_mapper_test;
    localparam int CLK_NS = 10;
    localparam int NB     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic [12:0] ppu_addr = 13'h0000;
    logic [3:0]  prg_bank;
    logic [17:0] chr_addr;
    logic        nt_page;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [7:0] chr_m [8];
    logic [3:0] pa_m, pb_m;
    bit         swap_m;

    nbm_mapper #(.PRG_BANKS(NB)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .ppu_addr (ppu_addr),
        .prg_bank (prg_bank),
        .chr_addr (chr_addr),
        .nt_page  (nt_page)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic chk_chr(input string tag);
        for (int b = 0; b < 8; b++) begin
            logic [9:0] lo;
            lo = 10'h2A5 ^ 10'(b * 67);
            ppu_addr = {b[2:0], lo};
            #1;
            check($sformatf("%s R6 bank%0d", tag, b), 32'(chr_addr), 32'({chr_m[b], lo}));
        end
    endtask

    task automatic chk_prg(input string tag);
        for (int w = 0; w < 4; w++) begin
            logic [3:0] e;
            case (w)
                0: e = swap_m ? 4'(NB - 2) : pa_m;
                1: e = pb_m;
                2: e = swap_m ? pa_m : 4'(NB - 2);
                default: e = 4'(NB - 1);
            endcase
            cpu_addr = 16'h8000 | 16'(w << 13) | 16'h0123;
            #1;
            check($sformatf("%s win%0d", tag, w), 32'(prg_bank), 32'(e));
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [9];
        int          kind [9];
        offs = '{12'h000, 12'h002, 12'h040, 12'h001, 12'h004, 12'h080, 12'h003, 12'h006, 12'h0C0};
        kind = '{0, 1, 1, 2, 2, 2, 3, 3, 3};

        for (int i = 0; i < 8; i++) chr_m[i] = 8'(i);
        pa_m = 4'd0; pb_m = 4'd1; swap_m = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk_chr("R1 reset");
        chk_prg("R1 R9 reset");
        ppu_addr = 13'h0400; #1;
        check("R1 R7 reset vertical A10=1", 32'(nt_page), 32'd1);
        ppu_addr = 13'h0800; #1;
        check("R1 R7 reset vertical A11=1", 32'(nt_page), 32'd0);

        // R2 R3 R4 R12: every alias in every character page.
        for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 9; j++) begin
                logic [15:0] a;
                logic [7:0]  d;
                int          idx;
                bit          noisy;
                noisy = (j % 2) == 1;
                d = 8'(p * 53 + j * 29 + 7) | 8'hA0;
                a = 16'(16'hB000 + p * 16'h1000) | {4'h0, offs[j]} | (noisy ? 16'h0A30 : 16'h0000);
                idx = 2 * p + (kind[j] >= 2 ? 1 : 0);
                if (kind[j] == 0 || kind[j] == 2) chr_m[idx][3:0] = d[3:0];
                else                              chr_m[idx][7:4] = d[3:0];
                wr(a, d);
                chk_chr($sformatf("%s%s R12 addr %0h", (kind[j] < 2) ? "R2" : "R3",
                                  noisy ? " R4" : "", a));
            end
        end

        // R5: near-miss addresses, foreign pages and strobe-low cycles.
        wr(16'hB005, 8'hFF);
        wr(16'hC008, 8'hFF);
        wr(16'hD041, 8'hFF);
        wr(16'hF000, 8'hFF);
        wr(16'h7000, 8'hFF);
        wr(16'h8001, 8'hFF);
        wr(16'h9001, 8'hFF);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 16'hE000; cpu_data = 8'h0F;
        @(negedge clk);
        cpu_addr = 16'h8000;
        @(negedge clk);
        chk_chr("R5 ignored");
        chk_prg("R5 ignored");
        ppu_addr = 13'h0400; #1;
        check("R5 mirroring kept", 32'(nt_page), 32'd1);

        // R7: each mode against all A11/A10 combinations.
        for (int m = 0; m < 4; m++) begin
            wr(16'h9000 | 16'h0A30, {6'b101101, m[1:0]});
            for (int a = 0; a < 4; a++) begin
                logic e;
                case (m)
                    0: e = a[0];
                    1: e = a[1];
                    2: e = 1'b0;
                    default: e = 1'b1;
                endcase
                ppu_addr = 13'(a << 10) | 13'h0155;
                #1;
                check($sformatf("R7 mode%0d a11a10=%0d", m, a), 32'(nt_page), 32'(e));
            end
        end

        // R9 R11: program bank loads, reduced modulo the bank count.
        wr(16'h8000, 8'hF7); pa_m = 4'h7;
        wr(16'hA000, 8'h2B); pb_m = 4'hB;
        chk_prg("R9 R11 unswapped");

        // R8 R10: swap through both aliases, junk in unused data bits.
        wr(16'h9002, 8'h02); swap_m = 1'b1;
        chk_prg("R8 R10 swap via 9002");
        wr(16'h9080, 8'hFD); swap_m = 1'b0;
        chk_prg("R8 clear via 9080 bit1=0");
        wr(16'h9080, 8'h06); swap_m = 1'b1;
        chk_prg("R8 R10 swap via 9080");
        wr(16'h8A30, 8'h35); pa_m = 4'h5;
        chk_prg("R10 R4 R11 bank load while swapped");
        wr(16'hA000, 8'h10); pb_m = 4'h0;
        chk_prg("R10 R11 window A while swapped");
        chk_chr("R5 prg writes leave chr");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule